// File: doc/BRIEF.md
# Triggered Capture Scope

An on-chip logic analyser. Once armed, it stores one 32-bit probe word per clock in a circular buffer. A trigger input ends the recording after a programmable number of further clocks. The stop delay sets where the captured window sits. With a delay of zero the buffer keeps the history that led up to the trigger. With a delay equal to the buffer depth the buffer keeps only what followed it. Any value in between splits the window.

A host reaches the scope through a minimal Wishbone slave with a single address bit. Address 0 is a control/status word. Writing it with the rearm bit set loads a new delay and starts a fresh recording. Address 1 is the sample port. After the scope stops, each read of this port returns the next stored sample, starting with the oldest.

Top module: `trig_scope`

## Requirements
- R1: While armed and not stopped, the scope writes `probe_i` into a circular buffer of 2^AW entries (1024 by default) at every rising clock edge. The buffer wraps and overwrites its oldest entry.
- R2: The trigger is ignored until 2^AW samples have been written since the last rearm. Status bit 31 (primed) reads 1 from then on. With the rearm accepted at edge E0, a trigger sampled at edge E(2^AW) is ignored and one sampled at edge E(2^AW + 1) is taken.
- R3: The trigger sample is always written. With a delay D, exactly D further samples are written after it, and then recording stops. Status bit 30 (triggered) and bit 29 (stopped) stay set until the next rearm.
- R4: With D = 0, the newest stored sample is the probe value at the trigger clock. With D at or above the depth, every stored sample comes from a clock after the trigger clock.
- R5: Once stopped, each read of address 1 returns one sample and advances the read position. The first read returns the oldest entry, the following reads run in recording order, and after the newest entry the reads wrap to the oldest again.
- R6: A read of address 1 while the scope is not stopped returns zero and does not move the read position.
- R7: A write to address 0 with bit 28 set rearms the scope. It loads the delay from bits [DLYW-1:0] (default [15:0]), sets armed, clears primed, triggered and stopped, and restarts the fill count. A write to address 0 with bit 28 clear, and any write to address 1, changes nothing.
- R8: When a rearm write and a trigger fall on the same clock, the rearm wins: the trigger is dropped and all flags read as after a plain rearm.
- R9: The status word read at address 0 is {primed, triggered, stopped, armed} in bits [31:28]. Bits [27:DLYW] are zero and the delay is in bits [DLYW-1:0]. After reset, every field reads zero.
- R10: `wb_ack_o` goes high for exactly one clock, in the cycle after each clock on which `wb_cyc_i` and `wb_stb_i` are both high, and stays low otherwise. `wb_stall_o` is always zero. Read data is valid while ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture and bus |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_i | input | DW | Word recorded on each clock |
| trig_i | input | 1 | Trigger request, sampled each clock |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 1 | 0 selects control/status, 1 selects sample port |
| wb_dat_i | input | DW | Write data |
| wb_ack_o | output | 1 | Acknowledge, one clock after the strobe |
| wb_stall_o | output | 1 | Always low |
| wb_dat_o | output | DW | Read data |

## Verification
A rearm write and a trigger can land on the same edge. The bench provokes this by raising the trigger in the very cycle its control-word strobe is accepted, after the buffer has primed. It then reads the status word and requires the plain post-rearm value: no triggered flag, no stopped flag, the fresh delay. The other close call is the end of priming. The bench counts edges from the accepted rearm and places a one-clock trigger on the last filling edge, where it must be ignored. It then places a trigger on the edge after, where it must stop the capture.

// File: rtl/scope_pkg.sv
// Shared definitions for the triggered capture scope.
// Assumes the bus word is at least 32 bits wide so the status bits fit.
package scope_pkg;
    localparam int unsigned ST_ARMED  = 28;   // also the rearm bit on writes
    localparam int unsigned ST_STOP   = 29;
    localparam int unsigned ST_TRIG   = 30;
    localparam int unsigned ST_PRIMED = 31;

    typedef struct packed {
        logic primed;
        logic triggered;
        logic stopped;
        logic armed;
    } sc_flags_t;
endpackage

// File: rtl/ts_ctrl.sv
// Capture sequencer: tracks arming, buffer fill, trigger and stop delay.
// Assumes rearm_req is a single-cycle pulse from the bus decoder.
module ts_ctrl #(
    parameter int unsigned AW   = 10,
    parameter int unsigned DLYW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    input  logic                  rearm_req,
    input  logic [DLYW-1:0]       rearm_dly,
    output logic                  wr_en,
    output logic                  stop_now,
    output scope_pkg::sc_flags_t  flags,
    output logic [DLYW-1:0]       delay
);
    logic [AW-1:0]   fill;
    logic [DLYW-1:0] hold;
    logic [DLYW-1:0] left;
    logic            recording;
    logic            trig_now;
    logic            counting;

    // Decode this cycle's capture actions from the registered state.
    always_comb begin
        recording = flags.armed & ~flags.stopped;
        trig_now  = recording & flags.primed & ~flags.triggered & trig_i;
        counting  = trig_now | (recording & flags.triggered);
        left      = trig_now ? delay : hold;
        wr_en     = recording & ~rearm_req;
        stop_now  = counting & (left == '0) & ~rearm_req;
    end

    // Sequencer state; a rearm takes priority over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            fill  <= '0;
            hold  <= '0;
            delay <= '0;
        end else if (rearm_req) begin
            flags <= '{primed: 1'b0, triggered: 1'b0, stopped: 1'b0, armed: 1'b1};
            fill  <= '0;
            hold  <= '0;
            delay <= rearm_dly;
        end else if (recording) begin
            if (!flags.primed) begin
                fill <= fill + 1'b1;
                if (fill == '1) flags.primed <= 1'b1;
            end
            if (counting) begin
                flags.triggered <= 1'b1;
                if (left == '0) flags.stopped <= 1'b1;
                else            hold <= left - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ts_buf.sv
// Circular sample store with write and read pointers.
// Assumes stop_now and rd_adv never occur together (reads advance only once stopped).
module ts_buf #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          stop_now,
    input  logic          rd_adv,
    input  logic [DW-1:0] probe_i,
    output logic [DW-1:0] rd_q
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // Store the probe word at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= probe_i;
    end

    // Move the pointers; at stop the read pointer lands on the oldest entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (stop_now)    rptr <= wptr + 1'b1;
            else if (rd_adv) rptr <= rptr + 1'b1;
        end
    end

    // Present the entry under the read pointer.
    assign rd_q = mem[rptr];
endmodule

// File: rtl/ts_bus.sv
// Single-address-bit Wishbone slave: control decode, status word and data port.
// Assumes a classic single-cycle strobe; never stalls.
module ts_bus #(
    parameter int unsigned DW   = 32,
    parameter int unsigned DLYW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wb_cyc_i,
    input  logic                 wb_stb_i,
    input  logic                 wb_we_i,
    input  logic                 wb_adr_i,
    input  logic [DW-1:0]        wb_dat_i,
    output logic                 wb_ack_o,
    output logic                 wb_stall_o,
    output logic [DW-1:0]        wb_dat_o,
    input  scope_pkg::sc_flags_t flags,
    input  logic [DLYW-1:0]      delay,
    input  logic [DW-1:0]        rd_q,
    output logic                 rearm_req,
    output logic [DLYW-1:0]      rearm_dly,
    output logic                 rd_adv
);
    logic          stb_ok;
    logic [DW-1:0] status;

    // Request decode and status assembly.
    always_comb begin
        stb_ok    = wb_cyc_i & wb_stb_i;
        rearm_req = stb_ok & wb_we_i & ~wb_adr_i & wb_dat_i[scope_pkg::ST_ARMED];
        rearm_dly = wb_dat_i[DLYW-1:0];
        rd_adv    = stb_ok & ~wb_we_i & wb_adr_i & flags.stopped;
        status    = '0;
        status[scope_pkg::ST_PRIMED] = flags.primed;
        status[scope_pkg::ST_TRIG]   = flags.triggered;
        status[scope_pkg::ST_STOP]   = flags.stopped;
        status[scope_pkg::ST_ARMED]  = flags.armed;
        status[DLYW-1:0]             = delay;
    end

    assign wb_stall_o = 1'b0;

    // Acknowledge and read data, one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_ack_o <= 1'b0;
            wb_dat_o <= '0;
        end else begin
            wb_ack_o <= stb_ok;
            if (stb_ok && !wb_we_i) begin
                if (!wb_adr_i)          wb_dat_o <= status;
                else if (flags.stopped) wb_dat_o <= rd_q;
                else                    wb_dat_o <= '0;
            end
        end
    end
endmodule

// File: rtl/trig_scope.sv
// Triggered capture scope top: records probe_i each clock, stops a
// programmable number of clocks after a trigger, read back over Wishbone.
// Assumes DW >= 32 and DLYW <= 28.
module trig_scope #(
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 10,
    parameter int unsigned DLYW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] probe_i,
    input  logic          trig_i,
    input  logic          wb_cyc_i,
    input  logic          wb_stb_i,
    input  logic          wb_we_i,
    input  logic          wb_adr_i,
    input  logic [DW-1:0] wb_dat_i,
    output logic          wb_ack_o,
    output logic          wb_stall_o,
    output logic [DW-1:0] wb_dat_o
);
    scope_pkg::sc_flags_t flg;
    logic [DLYW-1:0]      dly;
    logic [DLYW-1:0]      rearm_dly;
    logic                 rearm_req;
    logic                 rd_adv;
    logic                 wr_en;
    logic                 stop_now;
    logic [DW-1:0]        rd_q;

    ts_bus #(.DW(DW), .DLYW(DLYW)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
        .wb_ack_o(wb_ack_o), .wb_stall_o(wb_stall_o), .wb_dat_o(wb_dat_o),
        .flags(flg), .delay(dly), .rd_q(rd_q),
        .rearm_req(rearm_req), .rearm_dly(rearm_dly), .rd_adv(rd_adv)
    );

    ts_ctrl #(.AW(AW), .DLYW(DLYW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i),
        .rearm_req(rearm_req), .rearm_dly(rearm_dly),
        .wr_en(wr_en), .stop_now(stop_now), .flags(flg), .delay(dly)
    );

    ts_buf #(.DW(DW), .AW(AW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .stop_now(stop_now),
        .rd_adv(rd_adv), .probe_i(probe_i), .rd_q(rd_q)
    );
endmodule

// File: rtl/trig_scope_chk.sv
// Protocol and sequencing properties for trig_scope, attached by bind.
module trig_scope_chk #(
    parameter int unsigned DLYW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cyc,
    input logic                 stb,
    input logic                 ack,
    input logic                 stall,
    input logic                 rearm_req,
    input scope_pkg::sc_flags_t flg,
    input logic [DLYW-1:0]      dly
);
    p_ack_follows_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && stb) |=> ack);
    p_ack_needs_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc && stb) |=> !ack);
    p_never_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stall);
    p_trig_after_prime_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flg.triggered) |-> $past(flg.primed));
    p_stop_has_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flg.stopped |-> flg.triggered);
    p_stop_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flg.stopped && !rearm_req) |=> flg.stopped);
    p_rearm_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_req |=> (flg.armed && !flg.primed && !flg.triggered && !flg.stopped));
    p_delay_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rearm_req |=> $stable(dly));
endmodule

bind trig_scope trig_scope_chk #(.DLYW(DLYW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc(wb_cyc_i), .stb(wb_stb_i),
    .ack(wb_ack_o), .stall(wb_stall_o), .rearm_req(rearm_req),
    .flg(flg), .dly(dly)
);

// File: tb/sim_trig_scope.sv
// Self-checking bench for trig_scope.
module sim_trig_scope;
    localparam int unsigned DEPTH = 1024;
    localparam logic [31:0] REARM = 32'h1000_0000;
    // columns: stop delay, clocks before trigger, expected newest-sample offset from trigger
    localparam int TBL [5][3] = '{
        '{0,    1100, 0},
        '{1,    1200, 1},
        '{517,  1300, 517},
        '{1024, 1150, 1024},
        '{2000, 1100, 2000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0, adr = 1'b0;
    logic [31:0] wdat = '0;
    logic        ack, stall;
    logic [31:0] rdat;
    logic [31:0] probe;
    int unsigned pcnt = 0;
    int unsigned trig_k = 0;
    int          total = 0, bad = 0, ack_miss = 0;

    always #10ns clk = ~clk;

    function automatic logic [31:0] pv(input int unsigned k);
        return k ^ 32'h5A5A_0000;
    endfunction

    assign probe = pv(pcnt);
    always @(negedge clk) pcnt <= pcnt + 1;
    always @(posedge clk) if (trig_i) trig_k <= pcnt;

    trig_scope u0 (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .trig_i(trig_i),
        .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
        .wb_dat_i(wdat), .wb_ack_o(ack), .wb_stall_o(stall), .wb_dat_o(rdat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One single-cycle bus access; optionally raises the trigger on the same edge.
    task automatic xfer(input logic w, input logic a, input logic [31:0] d,
                        input logic with_trig, output logic [31:0] q);
        @(negedge clk);
        cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d; trig_i = with_trig;
        @(negedge clk);
        if (ack !== 1'b1) ack_miss++;
        q = rdat;
        cyc = 1'b0; stb = 1'b0; we = 1'b0; trig_i = 1'b0;
    endtask

    // Raise the trigger for one clock, j negedges after the current one.
    task automatic pulse(input int j);
        repeat (j) @(negedge clk);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R10 act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] q;
        int unsigned base;
        repeat (3) @(negedge clk);
        chk("R10 ack low in reset", {31'b0, ack}, 32'd0);
        chk("R10 stall low", {31'b0, stall}, 32'd0);
        rst_n = 1'b1;
        xfer(1'b0, 1'b0, '0, 1'b0, q);
        chk("R9 status after reset", q, 32'h0);
        @(negedge clk);
        chk("R10 ack lasts one clock", {31'b0, ack}, 32'd0);

        // Table-driven captures over several stop delays.
        for (int s = 0; s < 5; s++) begin
            xfer(1'b1, 1'b0, REARM | 32'(TBL[s][0]), 1'b0, q);
            if (s == 0) begin
                xfer(1'b0, 1'b1, '0, 1'b0, q);
                chk("R6 data read while recording", q, 32'h0);
            end
            pulse(TBL[s][1]);
            repeat (TBL[s][0] + 8) @(negedge clk);
            xfer(1'b0, 1'b0, '0, 1'b0, q);
            chk("R3 R9 status after stop", q, 32'hF000_0000 | 32'(TBL[s][0]));
            base = trig_k + TBL[s][2] - (DEPTH - 1);
            for (int i = 0; i < DEPTH; i++) begin
                xfer(1'b0, 1'b1, '0, 1'b0, q);
                chk((s == 0 || s >= 3) ? "R1 R4 R5 sample" : "R1 R3 R5 sample", q, pv(base + i));
            end
            xfer(1'b0, 1'b1, '0, 1'b0, q);
            chk("R5 wrap to oldest", q, pv(base));
        end

        // Writes without the rearm bit, and to the data port, are ignored.
        xfer(1'b1, 1'b0, 32'h0000_1234, 1'b0, q);
        xfer(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, q);
        xfer(1'b0, 1'b0, '0, 1'b0, q);
        chk("R7 ignored writes keep status", q, 32'hF000_07D0);
        xfer(1'b0, 1'b1, '0, 1'b0, q);
        chk("R7 ignored writes keep data", q, pv(base + 1));

        // Priming boundary: last filling edge ignored, next edge taken.
        xfer(1'b1, 1'b0, REARM, 1'b0, q);
        pulse(DEPTH - 1);
        repeat (5) @(negedge clk);
        xfer(1'b0, 1'b0, '0, 1'b0, q);
        chk("R2 trigger on final fill edge ignored", q, 32'h9000_0000);
        xfer(1'b1, 1'b0, REARM, 1'b0, q);
        pulse(DEPTH);
        repeat (5) @(negedge clk);
        xfer(1'b0, 1'b0, '0, 1'b0, q);
        chk("R2 trigger after priming taken", q, 32'hF000_0000);
        for (int i = 0; i < DEPTH; i++) begin
            xfer(1'b0, 1'b1, '0, 1'b0, q);
            if (i == DEPTH - 1) chk("R4 newest equals trigger sample", q, pv(trig_k));
        end

        // Rearm and trigger on the same edge.
        xfer(1'b1, 1'b0, REARM, 1'b0, q);
        repeat (1100) @(negedge clk);
        xfer(1'b1, 1'b0, REARM | 32'h5, 1'b1, q);
        xfer(1'b0, 1'b0, '0, 1'b0, q);
        chk("R8 rearm beats trigger", q, 32'h1000_0005);
        xfer(1'b0, 1'b1, '0, 1'b0, q);
        chk("R6 data zero after rearm", q, 32'h0);

        chk("R10 ack on every access", 32'(ack_miss), 32'd0);
        finish_run();
    end
endmodule